// File: doc/BRIEF.md
# Priority Bus Request Arbiter with Daisy-Chained Grants

This block decides which peripheral may interrupt the processor at the end of an instruction. Requests arrive on four major request levels, numbered 4 to 7. When the end-of-instruction strobe is sampled, the arbiter takes the highest level whose request line is active and whose number is strictly above the current processor priority. It raises the grant line for that level and only that level.

The grant then travels along a modelled chain of devices. Device 0 sits electrically nearest the processor. Each device spends one clock deciding: it either keeps the grant, if it is requesting at the granted level, or hands it to the next device. Devices that share a level are therefore ranked only by their position in the chain. The keeping device raises its win flag, and that flag serves as the acknowledgment. The arbiter drops the grant when it sees the acknowledgment. It also drops the grant after a timeout if the grant left the end of the chain and nobody took it.

Extra request inputs stand for requesters outside the modelled chain. They take part in level selection, but nothing in the chain answers for them. That makes them the way to exercise the timeout.

Top module: `busreq_chain_arbiter`

## Requirements
- R1: After reset, `bg_o`, `sack_o` and `win_o` are all zero.
- R2: The arbiter only starts a grant on a clock edge where `eoi_i` is high and no grant cycle is in progress. Requests without the strobe produce no grant.
- R3: A level n (4..7) qualifies only if n > `cpu_pri_i`. If no requesting level qualifies, no grant is issued. Priority 7 blocks every level, and priority 5 blocks levels 4 and 5.
- R4: Only the single highest qualifying level is granted. `bg_o` is one-hot, with bit k meaning level 4+k, and it appears on the outputs right after the strobe edge.
- R5: Within the granted level, the requesting device with the lowest chain index wins. Devices requesting at other levels pass the grant on untouched. Device i's level is `dev_lvl_i[2i+1:2i]`, coded as level minus 4.
- R6: Device k raises its bit in `win_o` exactly k+1 clocks after the edge that raised `bg_o`.
- R7: At most one `win_o` bit is set at a time, and `sack_o` is high exactly while a `win_o` bit is set.
- R8: `bg_o` stays high while the grant is in flight. It falls on the clock edge after `sack_o` is first seen high.
- R9: If no chain device takes the grant, `bg_o` stays high for exactly TMO clocks, then falls, and `win_o` remains zero.
- R10: After a grant is released, strobes are ignored until the chain is empty and `sack_o` is low. The winner's flag clears once the grant wave behind it has drained. The next strobe after that arbitrates normally.
- R11: Requests on `ext_br_i` compete in level selection exactly like chain requests at the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_pri_i | input | 3 | Current processor priority 0..7 |
| eoi_i | input | 1 | End-of-instruction strobe, one cycle |
| dev_req_i | input | NDEV | Request from each chain device, index 0 nearest |
| dev_lvl_i | input | NDEV*2 | Per-device level code (level minus 4) |
| ext_br_i | input | 4 | Requests from outside the chain, bit k = level 4+k |
| bg_o | output | 4 | Grant lines, bit k = level 4+k, registered |
| sack_o | output | 1 | Acknowledgment: some device holds the grant |
| win_o | output | NDEV | Registered one-hot win flag per device |

## Verification
If the level selector holds a wrong internal state, the result shows on `bg_o` immediately after the strobe edge. A chain node that passes a grant it should keep, or that keeps one it should pass, is visible by the expected win cycle (index+1 clocks later) as a wrong or missing `win_o` bit. A stuck arbiter state shows on the outputs in one of three ways. It can hold `bg_o` past the clock after `sack_o`. It can drop `bg_o` at a count other than TMO. Or it can answer a strobe during drain, which shows at once on `bg_o`. The sweep covers every request pattern of six devices against every processor priority, so these deviations surface within a few clocks of the arbitration that triggers them.

// File: rtl/bra_pkg.sv
package bra_pkg;
  localparam int NLVL     = 4;
  localparam int LVL_BASE = 4;
  localparam int LVLW     = $clog2(NLVL);

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_GRANT = 2'd1,
    ARB_DRAIN = 2'd2
  } arb_state_t;
endpackage

// File: rtl/bra_level_sel.sv
module bra_level_sel
  import bra_pkg::*;
(
  input  logic [NLVL-1:0] br_i,
  input  logic [2:0]      pri_i,
  output logic            valid_o,
  output logic [NLVL-1:0] sel_o
);
  logic [NLVL-1:0] qual;

  // a level takes part only when it lies strictly above processor priority
  for (genvar n = 0; n < NLVL; n++) begin : g_qual
    assign qual[n] = br_i[n] && ((LVL_BASE + n) > int'(pri_i));
  end

  always_comb begin
    sel_o   = '0;
    valid_o = 1'b0;
    for (int n = NLVL - 1; n >= 0; n--) begin
      if (!valid_o && qual[n]) begin
        sel_o[n] = 1'b1;
        valid_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bra_arbiter.sv
module bra_arbiter
  import bra_pkg::*;
#(
  parameter int TMO = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            eoi_i,
  input  logic            sel_valid_i,
  input  logic [NLVL-1:0] sel_i,
  input  logic            sack_i,
  input  logic            chain_busy_i,
  output logic [NLVL-1:0] bg_o,
  output logic            live_o
);
  localparam int TW = $clog2(TMO + 1);

  arb_state_t      st;
  logic [TW-1:0]   tmr;
  logic [NLVL-1:0] bg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ARB_IDLE;
      tmr  <= '0;
      bg_q <= '0;
    end else begin
      unique case (st)
        ARB_IDLE: begin
          if (eoi_i && sel_valid_i) begin
            bg_q <= sel_i;
            tmr  <= '0;
            st   <= ARB_GRANT;
          end
        end
        ARB_GRANT: begin
          if (sack_i || tmr == TW'(TMO - 1)) begin
            bg_q <= '0;
            st   <= ARB_DRAIN;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ARB_DRAIN: begin
          if (!chain_busy_i && !sack_i) st <= ARB_IDLE;
        end
        default: st <= ARB_IDLE;
      endcase
    end
  end

  assign bg_o   = bg_q;
  assign live_o = (st == ARB_GRANT);

  // R4
  bg_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bg_q));

  // R2
  bg_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|bg_q) |-> $past(eoi_i));

  // R8
  release_on_sack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ARB_GRANT && sack_i) |=> (bg_q == '0));

  // R9
  tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ARB_GRANT) |-> (tmr < TW'(TMO)));

  // R10
  drain_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ARB_DRAIN) |=> (bg_q == '0));
endmodule

// File: rtl/bra_chain_node.sv
module bra_chain_node
  import bra_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            live_i,
  input  logic            req_i,
  input  logic [LVLW-1:0] lvl_i,
  input  logic [NLVL-1:0] gin_i,
  output logic [NLVL-1:0] gout_o,
  output logic            win_o
);
  logic [NLVL-1:0] pass_q;
  logic            win_q;
  logic            take;

  assign take = live_i && req_i && gin_i[lvl_i] && !win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= '0;
      win_q  <= 1'b0;
    end else begin
      if (take)                       win_q <= 1'b1;
      else if (win_q && gin_i == '0)  win_q <= 1'b0;
      pass_q <= (take || win_q) ? '0 : gin_i;
    end
  end

  assign gout_o = pass_q;
  assign win_o  = win_q;

  // R6
  win_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(win_q) |-> $past(gin_i[lvl_i]));

  // R5
  win_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(win_q) |-> (gout_o == '0));
endmodule

// File: rtl/busreq_chain_arbiter.sv
module busreq_chain_arbiter
  import bra_pkg::*;
#(
  parameter int NDEV = 6,
  parameter int TMO  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cpu_pri_i,
  input  logic                 eoi_i,
  input  logic [NDEV-1:0]      dev_req_i,
  input  logic [NDEV*LVLW-1:0] dev_lvl_i,
  input  logic [NLVL-1:0]      ext_br_i,
  output logic [NLVL-1:0]      bg_o,
  output logic                 sack_o,
  output logic [NDEV-1:0]      win_o
);
  logic [NLVL-1:0] br;
  logic            sel_valid;
  logic [NLVL-1:0] sel;
  logic            live;
  logic            chain_busy;
  logic [NLVL-1:0] gchain [NDEV+1];
  logic [NDEV-1:0] win;

  // request lines: wired OR of devices per level plus outside requesters
  for (genvar n = 0; n < NLVL; n++) begin : g_br
    always_comb begin
      br[n] = ext_br_i[n];
      for (int i = 0; i < NDEV; i++) begin
        if (dev_req_i[i] && dev_lvl_i[i*LVLW +: LVLW] == LVLW'(n)) br[n] = 1'b1;
      end
    end
  end

  bra_level_sel u_sel (
    .br_i    (br),
    .pri_i   (cpu_pri_i),
    .valid_o (sel_valid),
    .sel_o   (sel)
  );

  bra_arbiter #(.TMO(TMO)) u_arb (
    .clk          (clk),
    .rst          (rst),
    .eoi_i        (eoi_i),
    .sel_valid_i  (sel_valid),
    .sel_i        (sel),
    .sack_i       (sack_o),
    .chain_busy_i (chain_busy),
    .bg_o         (gchain[0]),
    .live_o       (live)
  );

  for (genvar i = 0; i < NDEV; i++) begin : g_node
    bra_chain_node u_node (
      .clk    (clk),
      .rst    (rst),
      .live_i (live),
      .req_i  (dev_req_i[i]),
      .lvl_i  (dev_lvl_i[i*LVLW +: LVLW]),
      .gin_i  (gchain[i]),
      .gout_o (gchain[i+1]),
      .win_o  (win[i])
    );
  end

  always_comb begin
    chain_busy = 1'b0;
    for (int i = 1; i <= NDEV; i++) chain_busy = chain_busy || (gchain[i] != '0);
  end

  assign bg_o   = gchain[0];
  assign win_o  = win;
  assign sack_o = |win;

  // R7
  one_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win));

  // R3
  level_above_pri_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|gchain[0]) |-> $past(sel_valid));
endmodule

// File: tb/busreq_chain_arbiter_test.sv
module busreq_chain_arbiter_test;
  localparam int NDEV = 6;
  localparam int TMO  = 16;
  localparam int NLVL = 4;
  localparam int LVLW = 2;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [2:0]           cpu_pri = '0;
  logic                 eoi = 1'b0;
  logic [NDEV-1:0]      dev_req = '0;
  logic [NDEV*LVLW-1:0] dev_lvl;
  logic [NLVL-1:0]      ext_br = '0;
  logic [NLVL-1:0]      bg;
  logic                 sack;
  logic [NDEV-1:0]      win;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int code [NDEV] = '{0, 1, 0, 2, 3, 1};

  always #2 clk = ~clk;

  busreq_chain_arbiter #(.NDEV(NDEV), .TMO(TMO)) uut (
    .clk(clk), .rst(rst), .cpu_pri_i(cpu_pri), .eoi_i(eoi),
    .dev_req_i(dev_req), .dev_lvl_i(dev_lvl), .ext_br_i(ext_br),
    .bg_o(bg), .sack_o(sack), .win_o(win)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic arb(input int pri, input int pat, input int ext, input bit r10);
    int best = -1;
    int winner = -1;
    int cnt;
    for (int n = NLVL - 1; n >= 0; n--) begin
      bit any = ext[n];
      for (int i = 0; i < NDEV; i++) if (pat[i] && code[i] == n) any = 1'b1;
      if (best < 0 && any && (4 + n) > pri) best = n;
    end
    if (best >= 0)
      for (int i = NDEV - 1; i >= 0; i--) if (pat[i] && code[i] == best) winner = i;

    @(negedge clk);
    cpu_pri = 3'(pri); dev_req = NDEV'(pat); ext_br = NLVL'(ext); eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    if (best < 0) begin
      chk(bg == '0, "R3 no qualifying level", bg, 0);
      @(negedge clk); @(negedge clk);
      chk(bg == '0 && sack == 1'b0, "R3 stays quiet", bg, 0);
    end else begin
      chk(bg == NLVL'(1 << best), "R4 granted level", bg, 1 << best);
      if (winner >= 0) begin
        for (int s = 1; s <= winner + 1; s++) begin
          @(negedge clk);
          if (s <= winner) chk(win == '0, "R6 win too early", win, 0);
        end
        chk(win == NDEV'(1 << winner), "R5 R6 winner", win, 1 << winner);
        chk(sack == 1'b1, "R7 sack with win", sack, 1);
        chk(bg == NLVL'(1 << best), "R8 grant held", bg, 1 << best);
        @(negedge clk);
        chk(bg == '0, "R8 grant dropped", bg, 0);
        if (r10) begin
          eoi = 1'b1;
          @(negedge clk);
          eoi = 1'b0;
          chk(bg == '0, "R10 strobe in drain", bg, 0);
          @(negedge clk);
          chk(bg == '0, "R10 strobe in drain later", bg, 0);
        end
      end else begin
        cnt = 0;
        while (bg != '0 && cnt < TMO + 4) begin
          cnt++;
          @(negedge clk);
        end
        chk(cnt == TMO, "R9 timeout length", cnt, TMO);
        chk(win == '0, "R9 no winner", win, 0);
      end
      repeat (3 * NDEV + 4) @(negedge clk);
      chk(win == '0 && sack == 1'b0, "R10 drained", win, 0);
    end
    dev_req = '0; ext_br = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NDEV; i++) dev_lvl[i*LVLW +: LVLW] = LVLW'(code[i]);
    repeat (3) @(negedge clk);
    chk(bg == '0 && sack == 1'b0 && win == '0, "R1 reset state", bg, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bg == '0 && win == '0, "R1 after reset", win, 0);

    // R2: requests alone never raise a grant
    dev_req = '1; cpu_pri = 3'd0;
    repeat (5) @(negedge clk);
    chk(bg == '0, "R2 no strobe no grant", bg, 0);
    dev_req = '0;
    @(negedge clk);

    // full sweep of request patterns against every priority
    for (int p = 0; p < 8; p++)
      for (int pat = 0; pat < (1 << NDEV); pat++)
        arb(p, pat, 0, (pat % 16) == 5);

    // R11: outside requesters competing with chain devices
    arb(0, 6'b001000, 4'b1000, 1'b0);  // R11 level 7 outside beats level 6 device
    arb(0, 6'b000010, 4'b0001, 1'b0);  // R11 level 5 device beats level 4 outside
    arb(6, 6'b000000, 4'b1000, 1'b0);  // R11 R9 outside alone above priority
    arb(7, 6'b000000, 4'b1000, 1'b0);  // R3 R11 priority 7 blocks outside too
    arb(3, 6'b000001, 4'b0100, 1'b0);  // R11 level 6 outside with level 4 device

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule